// File: doc/BRIEF.md
# Split High/Low Clock Divider with Edge-Counted Phase Offset

This block divides a fast input clock by an integer ratio. The high phase and the low phase of the output are each programmed with their own count, so the duty cycle is set along with the frequency. A synchronous restart input puts the divider into an idle state. When the restart is released, the first output rising edge can be delayed by a programmed number of input rising edges. A start-high option makes the divider idle high and open with a low phase. An optional correction stretches each high phase by half an input cycle when the total ratio is odd. It does this with a falling-edge register, so odd ratios can give a symmetric output. A bypass select routes the input clock straight to the output.

Each output channel of a clock fan-out tree uses one instance. Restart pulses applied to all channels at once align them, and each channel's own offset then places its edges.

Top module: `hl_clk_div`

## Requirements
- R1: With correction off and bypass off, the output stays high for exactly N+1 input cycles and low for exactly M+1 input cycles, where N is `high_cnt_i` and M is `low_cnt_i`, each an unsigned 4-bit value.
- R2: With correction on and N+M even, the output widths are the same as in R1.
- R3: With correction on and N+M odd, the output high time is N+1.5 input cycles and the low time is M+0.5 input cycles. This gives exactly 50% when M = N+1 and the input duty is 50%.
- R4: While `sync_i` is sampled high on an input rising edge, the divider output holds at its idle level: high when `start_high_i` is 1, otherwise low.
- R5: With `start_high_i` = 0, the first output rising edge after `sync_i` is released comes on input rising edge 1+P. Edge 1 is the first rising edge that samples `sync_i` low, and P is the unsigned 5-bit `ofs_i`.
- R6: With `start_high_i` = 1, the output falls on input edge 1+P and first rises on input edge 1+P+M+1.
- R7: A change to N, M or the correction enable made while the divider runs does not affect the period in progress. The new values take effect from the next low-to-high output transition.
- R8: With `bypass_i` = 1, the output equals the input clock.
- R9: Out of reset the output is low. The divider then behaves as if a restart with P = 0 and start-low had just been released, and it rises on the first input rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Synchronous restart, active high |
| bypass_i | input | 1 | Route the input clock directly to the output |
| start_high_i | input | 1 | Idle high and open with a low phase |
| dcc_en_i | input | 1 | Enable half-cycle stretch for odd ratios |
| high_cnt_i | input | 4 | High phase length minus one (N) |
| low_cnt_i | input | 4 | Low phase length minus one (M) |
| ofs_i | input | 5 | Delay of the first rising edge in input edges (P) |
| clk_o | output | 1 | Divided or bypassed clock |

## Verification
The bench time-stamps every output edge and converts the widths and the first-edge delay into half input cycles. Directed settings cover several cases. Equal N and M with correction on show that even ratios are left alone. M = N+1 and a lopsided odd pair show that the half-cycle stretch is added and moves time from the low phase to the high phase. Zero and non-zero offsets with and without start-high show whether the low count is folded into the initial delay. Random settings from a fixed seed mix all fields. A change of N and M made in mid-period shows whether the update waits for the next rising boundary.

// File: rtl/hl_div_pkg.sv
package hl_div_pkg;
  localparam int unsigned CNT_W_DEF = 4;
  localparam int unsigned OFS_W_DEF = 5;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } ph_state_e;
endpackage

// File: rtl/hl_div_cfg_reg.sv
module hl_div_cfg_reg #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic             dcc_i,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] m_o,
  output logic             stretch_o
);
  logic [CNT_W-1:0] n_q, m_q;
  logic             dcc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      m_q   <= '0;
      dcc_q <= 1'b0;
    end else if (load_i) begin
      n_q   <= n_i;
      m_q   <= m_i;
      dcc_q <= dcc_i;
    end
  end

  assign n_o = n_q;
  assign m_o = m_q;
  // ratio N+M+2 is odd exactly when N+M is odd
  assign stretch_o = dcc_q & (n_q[0] ^ m_q[0]);
endmodule

// File: rtl/hl_div_seq.sv
module hl_div_seq
  import hl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned OFS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             start_high_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] n_new_i,
  input  logic [CNT_W-1:0] m_lat_i,
  output logic             lvl_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OFS_W-1:0] wait_o,
  output logic             load_cfg_o
);
  ph_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFS_W-1:0] wait_q;
  logic             lvl_q;
  logic             phase_end;

  assign phase_end  = (st_q == PH_RUN) ? (cnt_q == '0) : (wait_q == '0);
  assign load_cfg_o = sync_i | (phase_end & ~lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      lvl_q  <= 1'b0;
    end else if (sync_i) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= ofs_i;
      lvl_q  <= start_high_i;
    end else if (!phase_end) begin
      if (st_q == PH_RUN) cnt_q  <= cnt_q - 1'b1;
      else                wait_q <= wait_q - 1'b1;
    end else begin
      st_q <= PH_RUN;
      if (lvl_q) begin
        lvl_q <= 1'b0;
        cnt_q <= m_lat_i;
      end else begin
        lvl_q <= 1'b1;
        cnt_q <= n_new_i;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign run_o  = (st_q == PH_RUN);
  assign cnt_o  = cnt_q;
  assign wait_o = wait_q;
endmodule

// File: rtl/hl_div_half_ext.sv
module hl_div_half_ext #(
  parameter bit EN_DCC = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic stretch_i,
  output logic div_o
);
  generate
    if (EN_DCC) begin : g_dcc
      logic tail_q;
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tail_q <= 1'b0;
        else         tail_q <= lvl_i;
      end
      // hold high until the falling input edge after the posedge fall
      assign div_o = lvl_i | (tail_q & stretch_i);
    end else begin : g_nodcc
      logic unused_stretch;
      assign unused_stretch = stretch_i;
      assign div_o = lvl_i;
    end
  endgenerate
endmodule

// File: rtl/hl_clk_div.sv
module hl_clk_div
  import hl_div_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned OFS_W  = OFS_W_DEF,
  parameter bit          EN_DCC = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             bypass_i,
  input  logic             start_high_i,
  input  logic             dcc_en_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             clk_o
);
  logic [CNT_W-1:0] n_lat, m_lat, cnt;
  logic [OFS_W-1:0] wait_cnt;
  logic             lvl, run, load_cfg, stretch, div_clk;

  hl_div_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_cfg),
    .n_i       (high_cnt_i),
    .m_i       (low_cnt_i),
    .dcc_i     (dcc_en_i),
    .n_o       (n_lat),
    .m_o       (m_lat),
    .stretch_o (stretch)
  );

  hl_div_seq #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (sync_i),
    .start_high_i (start_high_i),
    .ofs_i        (ofs_i),
    .n_new_i      (high_cnt_i),
    .m_lat_i      (m_lat),
    .lvl_o        (lvl),
    .run_o        (run),
    .cnt_o        (cnt),
    .wait_o       (wait_cnt),
    .load_cfg_o   (load_cfg)
  );

  hl_div_half_ext #(.EN_DCC(EN_DCC)) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .stretch_i (stretch),
    .div_o     (div_clk)
  );

  assign clk_o = bypass_i ? clk_i : div_clk;
endmodule

// File: rtl/hl_clk_div_chk.sv
module hl_clk_div_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned OFS_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             start_high_i,
  input logic             lvl,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [OFS_W-1:0] wait_cnt,
  input logic [CNT_W-1:0] n_lat,
  input logic [CNT_W-1:0] m_lat
);
  p_sync_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (lvl == $past(start_high_i)));

  p_high_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && lvl) |-> (cnt <= n_lat));

  p_low_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !lvl) |-> (cnt <= m_lat));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_lat) |-> ($past(sync_i) || $rose(lvl)));

  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !run && wait_cnt != '0) |=> $stable(lvl));
endmodule

bind hl_clk_div hl_clk_div_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_i       (sync_i),
  .start_high_i (start_high_i),
  .lvl          (lvl),
  .run          (run),
  .cnt          (cnt),
  .wait_cnt     (wait_cnt),
  .n_lat        (n_lat),
  .m_lat        (m_lat)
);

// File: tb/sim_hl_clk_div.sv
`timescale 1ns/1ns
module sim_hl_clk_div;
  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;
  localparam int WDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0, sync = 1'b0, bypass = 1'b0;
  logic       sh = 1'b0, dcc = 1'b0;
  logic [3:0] n_v = 4'd1, m_v = 4'd1;
  logic [4:0] po = '0;
  logic       clk_out;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  hl_clk_div u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .bypass_i(bypass),
    .start_high_i(sh), .dcc_en_i(dcc), .high_cnt_i(n_v), .low_cnt_i(m_v),
    .ofs_i(po), .clk_o(clk_out)
  );

  always #(HALF) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int corr(input int n, input int m, input bit d);
    return (d && (((n + m) % 2) == 1)) ? 1 : 0;
  endfunction
  function automatic int exp_high(input int n, input int m, input bit d);
    return 2 * (n + 1) + corr(n, m, d);
  endfunction
  function automatic int exp_low(input int n, input int m, input bit d);
    return 2 * (m + 1) - corr(n, m, d);
  endfunction
  function automatic longint exp_delay(input int p, input bit s, input int m);
    return longint'(p + (s ? m + 1 : 0)) * PERIOD;
  endfunction

  task automatic run_case(input int n, input int m, input int p, input bit s, input bit d);
    longint t0, tr, tf, tr2;
    @(negedge clk);
    n_v = 4'(n); m_v = 4'(m); po = 5'(p); sh = s; dcc = d; sync = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(clk_out == s, "R4 idle level", clk_out, s);
    sync = 1'b0;
    t0 = $time - 1 + HALF;
    @(posedge clk_out); tr = $time;
    chk(tr - t0 == exp_delay(p, s, m), s ? "R6 first rise" : "R5 first rise",
        tr - t0, exp_delay(p, s, m));
    @(negedge clk_out); tf = $time;
    chk((tf - tr) / HALF == exp_high(n, m, d), d ? "R3/R2 high width" : "R1 high width",
        (tf - tr) / HALF, exp_high(n, m, d));
    @(posedge clk_out); tr2 = $time;
    chk((tr2 - tf) / HALF == exp_low(n, m, d), d ? "R3/R2 low width" : "R1 low width",
        (tr2 - tf) / HALF, exp_low(n, m, d));
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    longint t0, tr, tf, tr2, tf2;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    // R9 reset
    #(3 * PERIOD + 2);
    chk(clk_out == 1'b0, "R9 reset low", clk_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    t0 = $time + HALF;
    @(posedge clk_out); tr = $time;
    chk(tr == t0, "R9 first rise after reset", tr - t0, 0);

    // R8 bypass
    @(negedge clk); bypass = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      chk(clk_out == 1'b1, "R8 bypass high", clk_out, 1);
      @(negedge clk); #1;
      chk(clk_out == 1'b0, "R8 bypass low", clk_out, 0);
    end
    bypass = 1'b0;

    // directed
    run_case(0, 0, 0, 0, 0);
    run_case(3, 7, 0, 0, 0);
    run_case(2, 4, 3, 0, 1);   // R2 even ratio untouched
    run_case(5, 5, 0, 0, 1);   // R2
    run_case(3, 4, 0, 0, 1);   // R3 50%
    run_case(4, 1, 2, 0, 1);   // R3 lopsided
    run_case(2, 6, 4, 1, 0);   // R6
    run_case(15, 15, 31, 1, 1);
    run_case(0, 15, 0, 1, 0);

    // R7 mid-period change
    @(negedge clk);
    n_v = 4'd2; m_v = 4'd3; po = '0; sh = 1'b0; dcc = 1'b0; sync = 1'b1;
    repeat (2) @(negedge clk);
    sync = 1'b0;
    @(posedge clk_out); tr = $time;
    @(negedge clk); n_v = 4'd5; m_v = 4'd1;
    @(negedge clk_out); tf = $time;
    chk((tf - tr) / HALF == 6, "R7 old high", (tf - tr) / HALF, 6);
    @(posedge clk_out); tr2 = $time;
    chk((tr2 - tf) / HALF == 8, "R7 old low", (tr2 - tf) / HALF, 8);
    @(negedge clk_out); tf2 = $time;
    chk((tf2 - tr2) / HALF == 12, "R7 new high", (tf2 - tr2) / HALF, 12);
    @(posedge clk_out);
    chk(($time - tf2) / HALF == 4, "R7 new low", ($time - tf2) / HALF, 4);

    // random
    for (int k = 0; k < 24; k++) begin
      run_case(int'($urandom % 16), int'($urandom % 16), int'($urandom % 32),
               bit'($urandom % 2), bit'($urandom % 2));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule